// File: doc/BRIEF.md
# Quad Special Wakeup Register

This block is the hypervisor-facing register for special wakeup in a cluster of four cores. Software writes a request register to raise or drop a wakeup request for any subset of the cores in one access. It then polls a status register until completion is reported. Completion is treated as immediate: the shared done flag takes the requested value on the same write.

The access port carries a 32-bit register index and 64-bit data. Four index bits form a per-core select mask. These bits are removed before the index is compared with the register addresses, so one request register serves every core subset. Accesses to any other index are not implemented: reads return all ones, writes are dropped, and both raise a flag in the response. Each access gets exactly one response cycle after the request. The four per-core wakeup flags are driven as outputs.

Bit positions below use LSB-0 numbering on the ports. Index bit 15-k selects core k. Data bit 63 is the request value.

Top module: `quad_wakeup_reg`

## Requirements
- R1: After an active-low asynchronous reset, all four wakeup flags, the done flag, ack_o, unimp_o and rdata_o are 0.
- R2: Index bits 15:12 are cleared before decode, so they never change which register is hit. All other index bits must match exactly: for example, 0x108C0 is not the request register.
- R3: A write to the request register (default index 0x8C0) loads data bit 63 into the done flag. This happens even when no core-select bit is set.
- R4: On that same write, wake_o[k] takes data bit 63 for each k in 0..3 whose index bit 15-k is 1. The flags of unselected cores keep their values.
- R5: A read of the status register (default index 0x8C8) returns 0x4800_0000_0000_0000 (bits 62 and 59) when done is set, and 0 otherwise.
- R6: A read of any other index, including the request register, returns all ones with unimp_o set.
- R7: A write to any other index changes no flag and returns unimp_o set.
- R8: ack_o is high exactly in the cycle after a cycle with req_i high. unimp_o is only high together with ack_o. A write response carries rdata_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| idx_i | input | 32 | Register index including core-select bits |
| wdata_i | input | 64 | Write data |
| ack_o | output | 1 | Response valid, one cycle after req_i |
| rdata_o | output | 64 | Read data, 0 on write responses |
| unimp_o | output | 1 | Access hit an unimplemented index |
| wake_o | output | 4 | Per-core special wakeup flags |

## Verification
The bench builds the block with its default parameters: four cores, select mask at index bits 15:12, request at 0x8C0 and status at 0x8C8. With these values every subset pattern is reachable, including an empty mask, all four cores, and partial masks that must leave other cores untouched. Every masked variant of the status index is also reachable. An unmasked neighbouring bit (bit 16) confirms that only the four select bits are ignored in decode.

// File: rtl/quad_wakeup_pkg.sv
package quad_wakeup_pkg;
  typedef enum logic [1:0] {
    ACC_REQ   = 2'd0,
    ACC_STAT  = 2'd1,
    ACC_UNIMP = 2'd2
  } acc_kind_e;

  // MSB-0 bit n of a W-bit word sits at LSB-0 position W-1-n
  function automatic int msb0_pos(input int width, input int n);
    return width - 1 - n;
  endfunction
endpackage

// File: rtl/quad_wakeup_decode.sv
module quad_wakeup_decode
  import quad_wakeup_pkg::*;
#(
  parameter int          IDX_W     = 32,
  parameter int          NUM_CORES = 4,
  parameter int          SEL_MSB0  = 16,
  parameter logic [31:0] REQ_IDX   = 32'h8C0,
  parameter logic [31:0] STAT_IDX  = 32'h8C8
) (
  input  logic [IDX_W-1:0]     idx_i,
  output acc_kind_e            kind_o,
  output logic [NUM_CORES-1:0] sel_o
);
  logic [IDX_W-1:0] sel_mask;
  logic [IDX_W-1:0] idx_masked;

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_sel
    localparam int POS = msb0_pos(IDX_W, SEL_MSB0 + k);
    assign sel_o[k] = idx_i[POS];
  end

  always_comb begin
    sel_mask = '0;
    for (int k = 0; k < NUM_CORES; k++) sel_mask[msb0_pos(IDX_W, SEL_MSB0 + k)] = 1'b1;
  end

  assign idx_masked = idx_i & ~sel_mask;

  always_comb begin
    if (idx_masked == IDX_W'(REQ_IDX))       kind_o = ACC_REQ;
    else if (idx_masked == IDX_W'(STAT_IDX)) kind_o = ACC_STAT;
    else                                     kind_o = ACC_UNIMP;
  end
endmodule

// File: rtl/quad_wakeup_flags.sv
module quad_wakeup_flags #(
  parameter int NUM_CORES = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_req_i,
  input  logic                 val_i,
  input  logic [NUM_CORES-1:0] sel_i,
  output logic                 done_o,
  output logic [NUM_CORES-1:0] wake_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       done_o <= 1'b0;
    else if (wr_req_i) done_o <= val_i;
  end

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  wake_o[k] <= 1'b0;
      else if (wr_req_i && sel_i[k]) wake_o[k] <= val_i;
    end

    assert_unsel_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_req_i && !sel_i[k]) |=> $stable(wake_o[k]));
    assert_sel_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_req_i && sel_i[k]) |=> (wake_o[k] == $past(val_i)));
  end

  assert_idle_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req_i |=> ($stable(wake_o) && $stable(done_o)));
  assert_done_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_i |=> (done_o == $past(val_i)));
endmodule

// File: rtl/quad_wakeup_resp.sv
module quad_wakeup_resp
  import quad_wakeup_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int DONE_A_B0 = 1,
  parameter int DONE_B_B0 = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  acc_kind_e         kind_i,
  input  logic              done_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              unimp_o
);
  localparam logic [DATA_W-1:0] DONE_PAT =
    (DATA_W'(1) << msb0_pos(DATA_W, DONE_A_B0)) | (DATA_W'(1) << msb0_pos(DATA_W, DONE_B_B0));

  logic [DATA_W-1:0] rdata_d;
  logic              unimp_d;

  always_comb begin
    rdata_d = '0;
    unimp_d = req_i && (kind_i == ACC_UNIMP);
    if (!we_i) begin
      case (kind_i)
        ACC_STAT: rdata_d = done_i ? DONE_PAT : '0;
        default:  rdata_d = '1; // request register reads back as unimplemented
      endcase
      unimp_d = req_i && (kind_i != ACC_STAT);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_o   <= 1'b0;
      rdata_o <= '0;
      unimp_o <= 1'b0;
    end else begin
      ack_o   <= req_i;
      rdata_o <= req_i ? rdata_d : '0;
      unimp_o <= unimp_d;
    end
  end

  assert_ack_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);
  assert_ack_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);
  assert_stat_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && kind_i == ACC_STAT) |=> (rdata_o == (done_i ? DONE_PAT : '0) && !unimp_o));
endmodule

// File: rtl/quad_wakeup_reg.sv
module quad_wakeup_reg
  import quad_wakeup_pkg::*;
#(
  parameter int          IDX_W     = 32,
  parameter int          DATA_W    = 64,
  parameter int          NUM_CORES = 4,
  parameter int          SEL_MSB0  = 16,
  parameter int          VAL_B0    = 0,
  parameter logic [31:0] REQ_IDX   = 32'h8C0,
  parameter logic [31:0] STAT_IDX  = 32'h8C8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic                 ack_o,
  output logic [DATA_W-1:0]    rdata_o,
  output logic                 unimp_o,
  output logic [NUM_CORES-1:0] wake_o
);
  localparam int VAL_POS = msb0_pos(DATA_W, VAL_B0);

  acc_kind_e            kind;
  logic [NUM_CORES-1:0] sel;
  logic                 done;
  logic                 wr_req;
  logic                 unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign wr_req       = req_i && we_i && (kind == ACC_REQ);

  quad_wakeup_decode #(
    .IDX_W(IDX_W), .NUM_CORES(NUM_CORES), .SEL_MSB0(SEL_MSB0),
    .REQ_IDX(REQ_IDX), .STAT_IDX(STAT_IDX)
  ) decode_i (
    .idx_i (idx_i),
    .kind_o(kind),
    .sel_o (sel)
  );

  quad_wakeup_flags #(.NUM_CORES(NUM_CORES)) flags_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_req_i(wr_req),
    .val_i   (wdata_i[VAL_POS]),
    .sel_i   (sel),
    .done_o  (done),
    .wake_o  (wake_o)
  );

  quad_wakeup_resp #(.DATA_W(DATA_W)) resp_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .we_i   (we_i),
    .kind_i (kind),
    .done_i (done),
    .ack_o  (ack_o),
    .rdata_o(rdata_o),
    .unimp_o(unimp_o)
  );

  assert_unimp_with_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unimp_o |-> ack_o);
  assert_unimp_read_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && kind == ACC_UNIMP) |=> (unimp_o && rdata_o == '1));
  assert_unimp_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && kind == ACC_UNIMP) |=> (unimp_o && rdata_o == '0 && $stable(wake_o)));
endmodule

// File: tb/quad_wakeup_reg_tb_top.sv
module quad_wakeup_reg_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [31:0] idx_i = '0;
  logic [63:0] wdata_i = '0;
  logic        ack_o;
  logic [63:0] rdata_o;
  logic        unimp_o;
  logic [3:0]  wake_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done_run = 1'b0;

  always #5 clk_i = ~clk_i;

  quad_wakeup_reg dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .idx_i(idx_i),
    .wdata_i(wdata_i), .ack_o(ack_o), .rdata_o(rdata_o), .unimp_o(unimp_o), .wake_o(wake_o)
  );

  localparam logic [63:0] ONE  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] DPAT = 64'h4800_0000_0000_0000;
  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic        we;
    logic [31:0] idx;
    logic [63:0] wd;
    logic [63:0] exp_rd;
    logic        exp_un;
    logic [3:0]  exp_wk;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{1'b0, 32'h0000_08C8, 64'h0, 64'h0, 1'b0, 4'b0000},
    '{1'b1, 32'h0000_88C0, ONE,   64'h0, 1'b0, 4'b0001},
    '{1'b0, 32'h0000_08C8, 64'h0, DPAT,  1'b0, 4'b0001},
    '{1'b0, 32'h0000_F8C8, 64'h0, DPAT,  1'b0, 4'b0001},
    '{1'b1, 32'h0000_38C0, ONE,   64'h0, 1'b0, 4'b1101},
    '{1'b1, 32'h0000_48C0, 64'h0, 64'h0, 1'b0, 4'b1101},
    '{1'b0, 32'h0000_08C8, 64'h0, 64'h0, 1'b0, 4'b1101},
    '{1'b1, 32'h0000_08C0, ONE,   64'h0, 1'b0, 4'b1101},
    '{1'b0, 32'h0000_08C8, 64'h0, DPAT,  1'b0, 4'b1101},
    '{1'b1, 32'h0001_08C0, ALL1,  64'h0, 1'b1, 4'b1101},
    '{1'b0, 32'h0000_08C8, 64'h0, DPAT,  1'b0, 4'b1101},
    '{1'b1, 32'h0000_F8C0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 1'b0, 4'b0000},
    '{1'b0, 32'h0000_08C0, 64'h0, ALL1,  1'b1, 4'b0000},
    '{1'b1, 32'h0000_0100, ALL1,  64'h0, 1'b1, 4'b0000},
    '{1'b0, 32'h0000_08C8, 64'h0, 64'h0, 1'b0, 4'b0000},
    '{1'b1, 32'h0000_F8C0, ONE,   64'h0, 1'b0, 4'b1111}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [31:0] idx, input logic [63:0] wd);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; idx_i = idx; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; idx_i = '0; wdata_i = '0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done_run) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #12;
    // R1: reset state
    check(wake_o == 4'b0 && !ack_o && !unimp_o && rdata_o == '0, "R1 reset outputs",
          {ack_o, unimp_o, wake_o}, 64'h0);
    @(negedge clk_i); rst_ni = 1'b1;

    for (int i = 0; i < 16; i++) begin
      access(VEC[i].we, VEC[i].idx, VEC[i].wd);
      // R2 R3 R4 R5 R6 R7 R8 by vector
      check(ack_o, $sformatf("R8 ack vec%0d", i), 64'(ack_o), 64'h1);
      check(rdata_o == VEC[i].exp_rd, $sformatf("R5/R6 rdata vec%0d", i), rdata_o, VEC[i].exp_rd);
      check(unimp_o == VEC[i].exp_un, $sformatf("R6/R7 unimp vec%0d", i), 64'(unimp_o), 64'(VEC[i].exp_un));
      check(wake_o == VEC[i].exp_wk, $sformatf("R4/R3 wake vec%0d", i), 64'(wake_o), 64'(VEC[i].exp_wk));
    end

    // R8: no request, no response
    @(negedge clk_i);
    check(!ack_o && !unimp_o, "R8 idle no ack", {ack_o, unimp_o}, 64'h0);

    // R3: done set with empty mask, then status read at masked alias R2
    access(1'b1, 32'h0000_08C0, ONE);
    access(1'b0, 32'h0000_58C8, 64'h0);
    check(rdata_o == DPAT, "R2 masked status alias", rdata_o, DPAT);
    check(wake_o == 4'b1111, "R4 empty mask holds", 64'(wake_o), 64'hF);

    // R1: reset mid-run clears flags and done
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    check(wake_o == 4'b0 && rdata_o == '0, "R1 async reset", 64'(wake_o), 64'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    access(1'b0, 32'h0000_08C8, 64'h0);
    check(rdata_o == '0 && !unimp_o, "R1 done cleared", rdata_o, 64'h0);

    done_run = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule